// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one decoded operand specifier into the memory address an instruction needs, or into the operand itself when no memory is involved. A request carries a mode code, the base register's index and value, an index register value, a signed constant from the instruction and a size code. The size code gives the access size d in bytes (1, 2, 4 or 8). The block returns the effective address, the operand when it can produce one, and, for the post-increment and pre-decrement modes, the new value of the base register together with its index and a write enable.

Nine modes finish without touching memory. They are accepted on a valid/ready handshake and report on a one-cycle `out_done` pulse in the following cycle, at a rate of one request per cycle. The memory-indirect mode owns a request/ready read port. It first reads a pointer at the base register's value, then reads the operand at that pointer, and waits as long as memory holds `mem_ready` low on each read. While that sequence runs, `in_ready` is low and an offered request stays waiting.

Back-pressure rules: a request moves only in a cycle where `in_valid` and `in_ready` are both high. A memory read is presented by `mem_req` with `mem_addr` and is held unchanged until a cycle with `mem_ready` high; `mem_rdata` is taken in that same cycle. `out_done` cannot be stalled: whoever consumes it must take the result in the cycle it is high.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_done`, `wb_en` and `mem_req` are 0 and `in_ready` is 1.
- R2: Mode 0 (register) and mode 1 (immediate) raise `out_done` in the cycle after acceptance with `out_opnd_valid`=1 and `out_is_mem`=0; the operand is the base value for mode 0 and the sign-extended constant for mode 1.
- R3: Modes 2 (constant + base), 3 (base), 4 (base + index) and 5 (constant alone) raise `out_done` in the cycle after acceptance with that address on `out_addr`, `out_is_mem`=1 and `out_opnd_valid`=0.
- R4: Mode 9 (scaled) gives constant + base + index × d, where size codes 0, 1, 2, 3 mean d = 1, 2, 4, 8.
- R5: Mode 7 (post-increment) gives the base value as the address and, with `out_done`, asserts `wb_en` with `wb_idx` = base index and `wb_val` = base + d.
- R6: Mode 8 (pre-decrement) gives base − d both as the address and as `wb_val`, with `wb_en` and `wb_idx` = base index.
- R7: `wb_en` is high only together with `out_done` of a mode 7 or mode 8 request.
- R8: Mode 6 (memory-indirect) reads at the base value first, then at the pointer returned; in the cycle after the second `mem_ready`, `out_done` rises with `out_addr` = pointer, `out_operand` = second read data, `out_is_mem`=1, `out_opnd_valid`=1.
- R9: `in_ready` is low from the cycle after a mode 6 request is accepted until the cycle after its second read completes; a request offered meanwhile is not taken.
- R10: While `mem_req` is high and `mem_ready` low, the next cycle keeps `mem_req` high and `mem_addr` unchanged.
- R11: Mode codes 10 to 15 complete like register mode but with `out_is_mem`=0, `out_opnd_valid`=0 and `wb_en`=0.
- R12: Requests in modes other than 6 offered in consecutive cycles are each accepted and each reported in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request |
| in_mode | input | 4 | Addressing mode code |
| in_base_idx | input | IDXW | Base register index |
| in_base_val | input | AW | Base register value |
| in_index_val | input | AW | Index register value |
| in_const | input | CW | Signed constant from the instruction |
| in_size | input | 2 | Access size code, d = 1 << code |
| out_done | output | 1 | Result valid for this cycle |
| out_addr | output | AW | Effective address |
| out_is_mem | output | 1 | Result refers to memory |
| out_operand | output | AW | Operand value |
| out_opnd_valid | output | 1 | `out_operand` is meaningful |
| wb_en | output | 1 | Base register update enable |
| wb_idx | output | IDXW | Base register index to update |
| wb_val | output | AW | New base register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | AW | Read data, valid with `mem_ready` |

## Verification
The hardest situation to reach is a memory-indirect sequence stalled on both reads while the next request is already waiting at the input, because it needs the memory side and the request side to line up over many cycles. The stimulus holds `in_valid` high across each indirect request and drives `mem_ready` from a pseudo-random stall pattern, so the address hold during stalls, the closed `in_ready` and the point where the waiting request finally enters are all compared against the model cycle by cycle. Bursts of back-to-back single-cycle modes with all four size codes and negative constants cover the scaling and sign extension.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  localparam int MODE_W = 4;
  localparam int SIZE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_REG  = 4'd0,
    AM_IMM  = 4'd1,
    AM_DISP = 4'd2,
    AM_RIND = 4'd3,
    AM_INDX = 4'd4,
    AM_ABS  = 4'd5,
    AM_MIND = 4'd6,
    AM_POST = 4'd7,
    AM_PRED = 4'd8,
    AM_SCAL = 4'd9
  } am_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PTR  = 2'd1,
    SQ_OPD  = 2'd2
  } seq_e;

  function automatic logic is_base_update(input logic [MODE_W-1:0] m);
    return (m == AM_POST) || (m == AM_PRED);
  endfunction

endpackage

// File: rtl/ea_const_ext.sv
module ea_const_ext #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic [CW-1:0] cst,
  output logic [AW-1:0] ext
);

  generate
    if (CW >= AW) begin : g_trunc
      assign ext = cst[AW-1:0];
    end else begin : g_sext
      assign ext = {{(AW-CW){cst[CW-1]}}, cst};
    end
  endgenerate

endmodule

// File: rtl/ea_step_calc.sv
module ea_step_calc
  import ea_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SIZE_W-1:0] size,
  input  logic [AW-1:0]     base,
  output logic [AW-1:0]     dec_val,
  output logic              upd_en,
  output logic [AW-1:0]     upd_val
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step;
  logic [AW-1:0] inc_val;

  assign step    = ONE << size;
  assign inc_val = base + step;
  assign dec_val = base - step;
  assign upd_en  = is_base_update(mode);
  assign upd_val = (mode == AM_PRED) ? dec_val : inc_val;

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SIZE_W-1:0] size,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     index,
  input  logic [AW-1:0]     cext,
  input  logic [AW-1:0]     dec_val,
  output logic [AW-1:0]     addr,
  output logic              is_mem,
  output logic [AW-1:0]     operand,
  output logic              opnd_valid
);

  logic [AW-1:0] scaled_idx;

  assign scaled_idx = index << size;

  always_comb begin
    addr       = '0;
    is_mem     = 1'b0;
    operand    = '0;
    opnd_valid = 1'b0;
    case (mode)
      AM_REG: begin
        operand    = base;
        opnd_valid = 1'b1;
      end
      AM_IMM: begin
        operand    = cext;
        opnd_valid = 1'b1;
      end
      AM_DISP: begin
        addr   = cext + base;
        is_mem = 1'b1;
      end
      AM_RIND, AM_MIND, AM_POST: begin
        addr   = base;
        is_mem = 1'b1;
      end
      AM_INDX: begin
        addr   = base + index;
        is_mem = 1'b1;
      end
      AM_ABS: begin
        addr   = cext;
        is_mem = 1'b1;
      end
      AM_PRED: begin
        addr   = dec_val;
        is_mem = 1'b1;
      end
      AM_SCAL: begin
        addr   = cext + base + scaled_idx;
        is_mem = 1'b1;
      end
      default: begin
        addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/ea_indirect_seq.sv
module ea_indirect_seq
  import ea_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          fin,
  output logic [AW-1:0] ptr
);

  seq_e          st;
  logic [AW-1:0] first_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      first_addr <= '0;
      ptr        <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st         <= SQ_PTR;
            first_addr <= start_addr;
          end
        end
        SQ_PTR: begin
          if (mem_ready) begin
            ptr <= mem_rdata;
            st  <= SQ_OPD;
          end
        end
        SQ_OPD: begin
          if (mem_ready) begin
            st <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req  = (st != SQ_IDLE);
  assign busy     = mem_req;
  assign mem_addr = (st == SQ_OPD) ? ptr : first_addr;
  assign fin      = (st == SQ_OPD) && mem_ready;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int IDXW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [IDXW-1:0]   in_base_idx,
  input  logic [AW-1:0]     in_base_val,
  input  logic [AW-1:0]     in_index_val,
  input  logic [CW-1:0]     in_const,
  input  logic [SIZE_W-1:0] in_size,
  output logic              out_done,
  output logic [AW-1:0]     out_addr,
  output logic              out_is_mem,
  output logic [AW-1:0]     out_operand,
  output logic              out_opnd_valid,
  output logic              wb_en,
  output logic [IDXW-1:0]   wb_idx,
  output logic [AW-1:0]     wb_val,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ready,
  input  logic [AW-1:0]     mem_rdata
);

  logic          accept;
  logic          start_ind;
  logic          busy;
  logic          fin;
  logic [AW-1:0] ptr;
  logic [AW-1:0] cext;
  logic [AW-1:0] dec_val;
  logic          upd_en;
  logic [AW-1:0] upd_val;
  logic [AW-1:0] c_addr;
  logic          c_is_mem;
  logic [AW-1:0] c_operand;
  logic          c_opv;

  ea_const_ext #(.CW(CW), .AW(AW)) u_ext (
    .cst (in_const),
    .ext (cext)
  );

  ea_step_calc #(.AW(AW)) u_step (
    .mode    (in_mode),
    .size    (in_size),
    .base    (in_base_val),
    .dec_val (dec_val),
    .upd_en  (upd_en),
    .upd_val (upd_val)
  );

  ea_addr_calc #(.AW(AW)) u_calc (
    .mode       (in_mode),
    .size       (in_size),
    .base       (in_base_val),
    .index      (in_index_val),
    .cext       (cext),
    .dec_val    (dec_val),
    .addr       (c_addr),
    .is_mem     (c_is_mem),
    .operand    (c_operand),
    .opnd_valid (c_opv)
  );

  ea_indirect_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_ind),
    .start_addr (c_addr),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .fin        (fin),
    .ptr        (ptr)
  );

  assign in_ready  = !busy;
  assign accept    = in_valid && in_ready;
  assign start_ind = accept && (in_mode == AM_MIND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done       <= 1'b0;
      out_addr       <= '0;
      out_is_mem     <= 1'b0;
      out_operand    <= '0;
      out_opnd_valid <= 1'b0;
      wb_en          <= 1'b0;
      wb_idx         <= '0;
      wb_val         <= '0;
    end else begin
      out_done <= 1'b0;
      wb_en    <= 1'b0;
      if (fin) begin
        out_done       <= 1'b1;
        out_addr       <= ptr;
        out_is_mem     <= 1'b1;
        out_operand    <= mem_rdata;
        out_opnd_valid <= 1'b1;
      end else if (accept && !start_ind) begin
        out_done       <= 1'b1;
        out_addr       <= c_addr;
        out_is_mem     <= c_is_mem;
        out_operand    <= c_operand;
        out_opnd_valid <= c_opv;
        wb_en          <= upd_en;
        wb_idx         <= in_base_idx;
        wb_val         <= upd_val;
      end
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_gen_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [MODE_W-1:0] in_mode,
  input logic [AW-1:0]     in_base_val,
  input logic              out_done,
  input logic              out_is_mem,
  input logic              out_opnd_valid,
  input logic              wb_en,
  input logic              mem_req,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_ready
);

  a_r3_one_cycle_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode != AM_MIND) |=> out_done);

  a_r7_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_done && out_is_mem));

  a_r8_first_read_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == AM_MIND) |=>
      (mem_req && mem_addr == $past(in_base_val)));

  a_r9_closed_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r11_reserved_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode > AM_SCAL) |=>
      (out_done && !out_is_mem && !out_opnd_valid && !wb_en));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;

  localparam int AW   = 32;
  localparam int CW   = 16;
  localparam int IDXW = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [3:0]      in_mode;
  logic [IDXW-1:0] in_base_idx;
  logic [AW-1:0]   in_base_val;
  logic [AW-1:0]   in_index_val;
  logic [CW-1:0]   in_const;
  logic [1:0]      in_size;
  logic            out_done;
  logic [AW-1:0]   out_addr;
  logic            out_is_mem;
  logic [AW-1:0]   out_operand;
  logic            out_opnd_valid;
  logic            wb_en;
  logic [IDXW-1:0] wb_idx;
  logic [AW-1:0]   wb_val;
  logic            mem_req;
  logic [AW-1:0]   mem_addr;
  logic            mem_ready;
  logic [AW-1:0]   mem_rdata;

  always #4 clk = ~clk;

  ea_gen #(.AW(AW), .CW(CW), .IDXW(IDXW)) u0 (.*);

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return (a ^ 32'hA5C3_0F1E) + 32'h0001_2345;
  endfunction

  assign mem_rdata = fmem(mem_addr);

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit run   = 0;
  bit b2b   = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5B;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // memory ready pattern, changed away from the active edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = stall_en ? (lfsr[1:0] == 2'b00) : 1'b1;
  end

  // behavioural reference model, advanced on each rising edge
  int          st = 0;
  logic [31:0] paddr, mptr;
  bit          e_done, e_mem, e_opv, e_wb;
  logic [31:0] e_addr, e_op, e_wval;
  logic [4:0]  e_widx;
  string       e_tag = "R2";
  logic [31:0] mc, mb, mx, md;

  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; e_done = 0; e_wb = 0;
    end else begin
      int st0;
      st0 = st;
      e_done = 0;
      e_wb = 0;
      if (st0 == 1 && mem_ready) begin
        mptr = fmem(paddr);
        st = 2;
      end else if (st0 == 2 && mem_ready) begin
        e_done = 1; e_addr = mptr; e_mem = 1; e_op = fmem(mptr); e_opv = 1;
        e_tag = "R8";
        st = 0;
      end
      if (st0 == 0 && in_valid) begin
        mc = 32'($signed(in_const));
        mb = in_base_val;
        mx = in_index_val;
        md = 32'd1 << in_size;
        if (in_mode == 4'd6) begin
          st = 1;
          paddr = mb;
        end else begin
          e_done = 1; e_mem = 1; e_opv = 0; e_addr = 0; e_op = 0;
          e_widx = in_base_idx;
          case (in_mode)
            4'd0: begin e_mem = 0; e_opv = 1; e_op = mb; e_tag = "R2"; end
            4'd1: begin e_mem = 0; e_opv = 1; e_op = mc; e_tag = "R2"; end
            4'd2: begin e_addr = mc + mb; e_tag = "R3"; end
            4'd3: begin e_addr = mb; e_tag = "R3"; end
            4'd4: begin e_addr = mb + mx; e_tag = "R3"; end
            4'd5: begin e_addr = mc; e_tag = "R3"; end
            4'd7: begin e_addr = mb; e_wb = 1; e_wval = mb + md; e_tag = "R5"; end
            4'd8: begin e_addr = mb - md; e_wb = 1; e_wval = mb - md; e_tag = "R6"; end
            4'd9: begin e_addr = mc + mb + mx * md; e_tag = "R4"; end
            default: begin e_mem = 0; e_tag = "R11"; end
          endcase
          if (b2b) e_tag = "R12";
        end
      end
    end
  end

  // comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      check("R9", "in_ready", 32'(in_ready), 32'(st == 0));
      check("R8", "mem_req", 32'(mem_req), 32'(st != 0));
      if (st != 0)
        check(stall_en ? "R10" : "R8", "mem_addr", mem_addr, (st == 1) ? paddr : mptr);
      check(e_tag, "out_done", 32'(out_done), 32'(e_done));
      check("R7", "wb_en", 32'(wb_en), 32'(e_done && e_wb));
      if (e_done) begin
        check(e_tag, "out_is_mem", 32'(out_is_mem), 32'(e_mem));
        check(e_tag, "out_opnd_valid", 32'(out_opnd_valid), 32'(e_opv));
        if (e_mem) check(e_tag, "out_addr", out_addr, e_addr);
        if (e_opv) check(e_tag, "out_operand", out_operand, e_op);
        if (e_wb) begin
          check(e_tag, "wb_idx", 32'(wb_idx), 32'(e_widx));
          check(e_tag, "wb_val", wb_val, e_wval);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic send(input logic [3:0] m, input logic [4:0] ri, input logic [31:0] b,
                      input logic [31:0] x, input logic [15:0] c, input logic [1:0] s);
    in_mode = m; in_base_idx = ri; in_base_val = b; in_index_val = x;
    in_const = c; in_size = s; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 0; in_base_idx = 0; in_base_val = 0;
    in_index_val = 0; in_const = 0; in_size = 0;
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    check("R1", "mem_req in reset", 32'(mem_req), 32'd0);
    check("R1", "out_done in reset", 32'(out_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "wb_en after reset", 32'(wb_en), 32'd0);
    check("R1", "in_ready after reset", 32'(in_ready), 32'd1);
    run = 1;
    // each mode once with gaps
    send(4'd0, 5'd3, 32'h1234_5678, 32'h0, 16'h0, 2'd0); idle(1);
    send(4'd1, 5'd3, 32'h0, 32'h0, 16'hFF80, 2'd0); idle(1);
    send(4'd2, 5'd4, 32'h0000_1000, 32'h0, 16'hFFFC, 2'd0); idle(1);
    send(4'd3, 5'd5, 32'h0000_2000, 32'h0, 16'h0, 2'd0); idle(1);
    send(4'd4, 5'd6, 32'h0000_3000, 32'h0000_0044, 16'h0, 2'd0); idle(1);
    send(4'd5, 5'd7, 32'h0, 32'h0, 16'h03E9, 2'd0); idle(1);
    for (int s = 0; s < 4; s++) begin
      send(4'd9, 5'd8, 32'h0000_4000, 32'h0000_0010, 16'h0064, 2'(s));
      send(4'd7, 5'd9, 32'h0000_5000, 32'h0, 16'h0, 2'(s));
      send(4'd8, 5'd10, 32'h0000_6000, 32'h0, 16'h0, 2'(s));
    end
    idle(1);
    send(4'd8, 5'd11, 32'h0000_0002, 32'h0, 16'h0, 2'd3); idle(1);
    send(4'd10, 5'd1, 32'hDEAD_BEEF, 32'h1, 16'h1, 2'd1); idle(1);
    send(4'd15, 5'd2, 32'hCAFE_F00D, 32'h2, 16'h2, 2'd2); idle(1);
    // memory-indirect without and with stalls, next request waiting
    send(4'd6, 5'd12, 32'h0000_8000, 32'h0, 16'h0, 2'd2);
    send(4'd0, 5'd1, 32'h0000_0077, 32'h0, 16'h0, 2'd0); idle(2);
    stall_en = 1;
    for (int k = 0; k < 6; k++) begin
      send(4'd6, 5'(k), 32'h0001_0000 + 32'(k * 8), 32'h0, 16'h0, 2'd3);
      send(4'd7, 5'(k), 32'h0000_0100 * 32'(k), 32'h0, 16'h0, 2'(k));
    end
    idle(4);
    stall_en = 0;
    // back-to-back single-cycle modes
    b2b = 1;
    for (int k = 0; k < 30; k++) begin
      int m;
      m = k % 10;
      if (m == 6) m = 9;
      send(4'(m), 5'(k), $urandom, $urandom, 16'($urandom), 2'($urandom));
    end
    idle(2);
    b2b = 0;
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      stall_en = ($urandom % 2) == 1;
      send(4'($urandom % 16), 5'($urandom), $urandom, $urandom, 16'($urandom), 2'($urandom));
      if (($urandom % 4) == 0) idle(1);
    end
    stall_en = 0;
    idle(10);
    summary();
  end

endmodule